// File: doc/BRIEF.md
# Word-to-Byte Card Data FIFO Engine

The engine sits between a host that moves 32-bit words and a card data port that moves one byte at a time. It holds a 16-entry ring of 32-bit words. A start pulse loads a byte counter from a 16-bit length and latches the transfer direction. In the receive direction, bytes from the card are packed little-endian into words and pushed into the ring, and the host pops them. In the transmit direction, the host pushes words and the engine pops them and sends them to the card, low byte first. The engine moves at most one byte per clock.

When the byte counter reaches zero, the engine raises sticky end-of-data and end-of-block flags. Once the ring has also drained, it drops its enable. While enabled, it reports occupancy flags for the active direction only, and it recomputes them every cycle from the ring occupancy.

Top module: `card_byte_fifo_engine`

## Requirements
- R1: After reset, xfer_en, data_end, block_end, bytes_left, host_pop_err, card_wr_valid, rx_flags and tx_flags are all zero.
- R2: A cycle with xfer_start high loads bytes_left from xfer_len, latches xfer_dir_rx (1 = card to host, 0 = host to card), sets xfer_en and clears data_end and block_end at the next edge.
- R3: In receive direction, card_rd_take is high only while xfer_en is set, bytes_left is nonzero, card_rdy is high and the ring holds fewer than 16 words. Each take decrements bytes_left by one.
- R4: Received bytes are packed little-endian: the first byte of each group of four lands in bits 7:0. A final partial word is pushed with its unused upper bytes zero.
- R5: In transmit direction, the engine pops a word only when no bytes of the previous word remain. It sends bits 7:0 first, then each next byte up, one per cycle, and it stops when bytes_left reaches zero. Each byte appears on card_wr_byte with card_wr_valid high for one cycle.
- R6: The ring is first-in first-out with 16 words. A push into a full ring is dropped. A host push counts only in transmit direction while xfer_en is set and bytes_left is nonzero.
- R7: A host pop that finds the ring empty, or that arrives while a transmit transfer still has bytes to send, returns host_rdata = 0 and raises host_pop_err for one cycle. A valid pop presents the oldest word on host_rdata at the next edge.
- R8: One edge after xfer_en is set with bytes_left at zero, data_end and block_end go high. They stay high until the next start.
- R9: When bytes_left is zero and the ring is empty, xfer_en clears at the next edge. While xfer_en is low, both flag vectors are zero.
- R10: Each 5-bit flag vector uses bit0 for active, bit1 for empty (0 words), bit2 for data available (nonzero), bit3 for full (16 words) and bit4 for the half flag. The half flag in rx_flags means 8 or more words. In tx_flags it means 8 or fewer words. The flags follow the occupancy in the same cycle it changes.
- R11: Only the vector of the latched direction is nonzero: rx_flags when receiving, tx_flags when transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Load counter and direction, begin transfer |
| xfer_dir_rx | input | 1 | Direction: 1 card to host, 0 host to card |
| xfer_len | input | 16 | Transfer length in bytes |
| host_push | input | 1 | Host word write strobe |
| host_wdata | input | 32 | Host word to push |
| host_pop | input | 1 | Host word read strobe |
| host_rdata | output | 32 | Popped word, valid the cycle after a pop |
| host_pop_err | output | 1 | One-cycle pulse for a rejected pop |
| card_rdy | input | 1 | Card has a byte ready |
| card_rd_byte | input | 8 | Byte offered by the card |
| card_rd_take | output | 1 | Byte consumed at this edge |
| card_wr_byte | output | 8 | Byte sent to the card |
| card_wr_valid | output | 1 | card_wr_byte is valid this cycle |
| xfer_en | output | 1 | Transfer enabled |
| bytes_left | output | 16 | Remaining byte count |
| data_end | output | 1 | Sticky: byte count reached zero |
| block_end | output | 1 | Sticky: block finished (same event) |
| rx_flags | output | 5 | Receive occupancy flags |
| tx_flags | output | 5 | Transmit occupancy flags |

## Verification
Several properties are checked on every cycle: the bound on ring occupancy, that a push into a full ring is dropped, that each moved byte decrements the counter by exactly one, that rejected pops read zero, that the end flags stay set, that the flag vectors never both show activity, and that both vectors are silent while idle. The bench scenarios are needed for the rest. They show the byte order inside packed and unpacked words and the zero fill of a partial final word. They show the stall when the card is not ready or the ring is full, and the resume after one word is popped. They also show the exact flag codes at empty and full occupancy, and the drain sequence that ends a transfer.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  localparam int unsigned FLAG_W    = 5;
  localparam int unsigned FL_ACTIVE = 0;
  localparam int unsigned FL_EMPTY  = 1;
  localparam int unsigned FL_AVAIL  = 2;
  localparam int unsigned FL_FULL   = 3;
  localparam int unsigned FL_HALF   = 4;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;

  // Occupancy flags for one direction. rx_side selects which half flag to use.
  function automatic logic [FLAG_W-1:0] level_flags(input int unsigned occ,
                                                    input int unsigned depth,
                                                    input logic rx_side);
    logic [FLAG_W-1:0] f;
    f            = '0;
    f[FL_ACTIVE] = 1'b1;
    f[FL_EMPTY]  = (occ == 0);
    f[FL_AVAIL]  = (occ != 0);
    f[FL_FULL]   = (occ == depth);
    f[FL_HALF]   = rx_side ? (occ >= depth / 2) : (occ <= depth / 2);
    return f;
  endfunction

endpackage

// File: rtl/cbf_ring.sv
module cbf_ring #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [OCC_W-1:0]  occ,
  output logic              full,
  output logic              empty
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [OCC_W-1:0]  occ_q;
  logic              push_ok;
  logic              pop_ok;

  // The write slot sits occ words past the read pointer, wrapping at DEPTH.
  function automatic logic [PTR_W-1:0] write_slot(input logic [PTR_W-1:0] rp,
                                                   input logic [OCC_W-1:0] n);
    return rp + n[PTR_W-1:0];
  endfunction

  assign full    = (occ_q == OCC_W'(DEPTH));
  assign empty   = (occ_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];
  assign occ     = occ_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[write_slot(rd_ptr, occ_q)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (pop_ok) rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH)); // R6

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (occ_q == OCC_W'(DEPTH))); // R6

endmodule

// File: rtl/cbf_rx_pack.sv
module cbf_rx_pack #(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WORD_W = 8 * WORD_BYTES,
  localparam int unsigned LW     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              last,
  input  logic [7:0]        in_byte,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);

  logic [WORD_W-1:0] acc_q;
  logic [LW-1:0]     lane_q;

  // Puts a byte into its little-endian lane of the partial word.
  function automatic logic [WORD_W-1:0] place_byte(input logic [WORD_W-1:0] acc,
                                                   input logic [7:0] b,
                                                   input logic [LW-1:0] lane);
    return acc | (WORD_W'(b) << (8 * lane));
  endfunction

  assign push_word = place_byte(acc_q, in_byte, lane_q);
  assign push      = take && ((lane_q == LW'(WORD_BYTES - 1)) || last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || push) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (take) begin
      acc_q  <= push_word;
      lane_q <= lane_q + LW'(1);
    end
  end

endmodule

// File: rtl/cbf_tx_unpack.sv
module cbf_tx_unpack #(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WORD_W = 8 * WORD_BYTES,
  localparam int unsigned LW     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              send,
  input  logic [WORD_W-1:0] head,
  output logic              has_left,
  output logic              pop,
  output logic [7:0]        out_byte,
  output logic              out_valid
);

  logic [WORD_W-9:0] rest_q;
  logic [LW-1:0]     left_q;
  logic [7:0]        byte_now;

  assign has_left = (left_q != '0);
  assign pop      = send && !has_left;
  assign byte_now = pop ? head[7:0] : rest_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rest_q    <= '0;
      left_q    <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= send;
      if (send) begin
        out_byte <= byte_now;
        if (pop) begin
          rest_q <= head[WORD_W-1:8];
          left_q <= LW'(WORD_BYTES - 1);
        end else begin
          rest_q <= rest_q >> 8;
          left_q <= left_q - LW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/card_byte_fifo_engine.sv
module card_byte_fifo_engine #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned LEN_W      = 16,
  localparam int unsigned WORD_W = 8 * WORD_BYTES,
  localparam int unsigned OCC_W  = $clog2(DEPTH) + 1,
  localparam int unsigned FW     = cbf_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_dir_rx,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              host_push,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_pop,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_pop_err,
  input  logic              card_rdy,
  input  logic [7:0]        card_rd_byte,
  output logic              card_rd_take,
  output logic [7:0]        card_wr_byte,
  output logic              card_wr_valid,
  output logic              xfer_en,
  output logic [LEN_W-1:0]  bytes_left,
  output logic              data_end,
  output logic              block_end,
  output logic [FW-1:0]     rx_flags,
  output logic [FW-1:0]     tx_flags
);
  import cbf_pkg::*;

  dir_e              dir_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              en_q;
  logic              end_q;
  logic [WORD_W-1:0] rdata_q;
  logic              perr_q;

  // Internal events, named for the assertions
  logic              cnt_zero;
  logic              rx_mode;
  logic              tx_counting;
  logic              eng_take;
  logic              eng_send;
  logic              finish_evt;
  logic              host_push_ok;
  logic              host_pop_ok;

  logic              ring_push;
  logic [WORD_W-1:0] ring_wdata;
  logic              ring_pop;
  logic [WORD_W-1:0] ring_head;
  logic [OCC_W-1:0]  ring_occ;
  logic              ring_full;
  logic              ring_empty;
  logic              pk_push;
  logic [WORD_W-1:0] pk_word;
  logic              up_left;
  logic              up_pop;
  logic [FW-1:0]     lvl;

  assign cnt_zero     = (cnt_q == '0);
  assign rx_mode      = (dir_q == DIR_RX);
  assign tx_counting  = en_q && !rx_mode && !cnt_zero;
  assign eng_take     = en_q && rx_mode && !cnt_zero && card_rdy && !ring_full;
  assign eng_send     = tx_counting && (up_left || !ring_empty);
  assign finish_evt   = en_q && cnt_zero && ring_empty;
  assign host_push_ok = host_push && tx_counting;
  assign host_pop_ok  = host_pop && !ring_empty && !tx_counting;

  assign ring_push  = rx_mode ? pk_push : host_push_ok;
  assign ring_wdata = rx_mode ? pk_word : host_wdata;
  assign ring_pop   = host_pop_ok || up_pop;

  cbf_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ring_push),
    .wdata (ring_wdata),
    .pop   (ring_pop),
    .head  (ring_head),
    .occ   (ring_occ),
    .full  (ring_full),
    .empty (ring_empty)
  );

  cbf_rx_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (xfer_start),
    .take      (eng_take),
    .last      (cnt_q == LEN_W'(1)),
    .in_byte   (card_rd_byte),
    .push      (pk_push),
    .push_word (pk_word)
  );

  cbf_tx_unpack #(.WORD_BYTES(WORD_BYTES)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (xfer_start),
    .send      (eng_send),
    .head      (ring_head),
    .has_left  (up_left),
    .pop       (up_pop),
    .out_byte  (card_wr_byte),
    .out_valid (card_wr_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= DIR_TX;
      cnt_q <= '0;
      en_q  <= 1'b0;
      end_q <= 1'b0;
    end else if (xfer_start) begin
      dir_q <= xfer_dir_rx ? DIR_RX : DIR_TX;
      cnt_q <= xfer_len;
      en_q  <= 1'b1;
      end_q <= 1'b0;
    end else begin
      if (eng_take || eng_send) cnt_q <= cnt_q - LEN_W'(1);
      if (en_q && cnt_zero)     end_q <= 1'b1;
      if (finish_evt)           en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      perr_q  <= 1'b0;
    end else begin
      perr_q <= host_pop && !host_pop_ok;
      if (host_pop) rdata_q <= host_pop_ok ? ring_head : '0;
    end
  end

  assign lvl = level_flags(int'(ring_occ), DEPTH, rx_mode);

  assign rx_flags      = (en_q && rx_mode)  ? lvl : '0;
  assign tx_flags      = (en_q && !rx_mode) ? lvl : '0;
  assign card_rd_take  = eng_take;
  assign xfer_en       = en_q;
  assign bytes_left    = cnt_q;
  assign data_end      = end_q;
  assign block_end     = end_q;
  assign host_rdata    = rdata_q;
  assign host_pop_err  = perr_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_take || eng_send) && !xfer_start) |=> (cnt_q == $past(cnt_q) - LEN_W'(1))); // R3

  AST_POP_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_pop_err |-> (host_rdata == '0)); // R7

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !xfer_start) |=> end_q); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (rx_flags == '0 && tx_flags == '0)); // R9

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !((|rx_flags) && (|tx_flags))); // R11

  AST_TAKE_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    card_rd_take |-> (ring_occ < OCC_W'(DEPTH) && card_rdy)); // R3

endmodule

// File: tb/card_byte_fifo_engine_test.sv
`timescale 1ns/1ps
module card_byte_fifo_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0;
  logic        xfer_dir_rx = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        host_push = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_pop = 1'b0;
  logic [31:0] host_rdata;
  logic        host_pop_err;
  logic        card_rdy = 1'b1;
  logic [7:0]  card_rd_byte;
  logic        card_rd_take;
  logic [7:0]  card_wr_byte;
  logic        card_wr_valid;
  logic        xfer_en;
  logic [15:0] bytes_left;
  logic        data_end;
  logic        block_end;
  logic [4:0]  rx_flags;
  logic [4:0]  tx_flags;

  card_byte_fifo_engine uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  // Card model: offers base+index, index advances on each take.
  logic [7:0] card_base = '0;
  logic [7:0] idx = '0;
  assign card_rd_byte = card_base + idx;
  always @(posedge clk) begin
    if (xfer_start) idx <= '0;
    else if (card_rd_take) idx <= idx + 8'd1;
  end

  // Card write recorder
  logic [7:0] rec [128];
  int rec_n = 0;
  always @(negedge clk) begin
    if (card_wr_valid && rec_n < 128) begin
      rec[rec_n] = card_wr_byte;
      rec_n++;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start(input logic dir, input logic [15:0] len, input logic [7:0] base);
    card_base   = base;
    rec_n       = 0;
    xfer_dir_rx = dir;
    xfer_len    = len;
    xfer_start  = 1'b1;
    tick();
    xfer_start  = 1'b0;
  endtask

  task automatic pop_word(output logic [31:0] d, output logic e);
    host_pop = 1'b1;
    tick();
    host_pop = 1'b0;
    d = host_rdata;
    e = host_pop_err;
  endtask

  task automatic push_word(input logic [31:0] w);
    host_push  = 1'b1;
    host_wdata = w;
    tick();
    host_push  = 1'b0;
  endtask

  task automatic wait_cnt0();
    for (int i = 0; i < 500 && bytes_left != 0; i++) tick();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && xfer_en; i++) tick();
  endtask

  // Expected packed word k: byte i of the stream is base+i, little-endian,
  // bytes at or past len are zero.
  function automatic logic [31:0] exp_word(input logic [7:0] base, input int k, input int len);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = base + 8'(4 * k + j);
    return w;
  endfunction

  // Vectors: {dir_rx, len, base}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 16'd8,  8'h10},
    {1'b1, 16'd5,  8'h40},
    {1'b1, 16'd3,  8'hA0},
    {1'b1, 16'd64, 8'h00},
    {1'b0, 16'd8,  8'h21},
    {1'b0, 16'd6,  8'h70},
    {1'b0, 16'd1,  8'hC3},
    {1'b0, 16'd13, 8'h05}
  };

  logic        vdir;
  int          vlen;
  logic [7:0]  vbase;
  logic [31:0] d;
  logic        e;
  int          nw;
  int          bad;

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check_eq("R1 xfer_en", 32'(xfer_en), 0);
    check_eq("R1 data_end", 32'(data_end), 0);
    check_eq("R1 bytes_left", 32'(bytes_left), 0);
    check_eq("R1 flags", {22'd0, rx_flags, tx_flags}, 0);
    check_eq("R1 wr_valid/pop_err", {30'd0, card_wr_valid, host_pop_err}, 0);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      vdir  = VEC[v][24];
      vlen  = int'(VEC[v][23:8]);
      vbase = VEC[v][7:0];
      nw    = (vlen + 3) / 4;
      do_start(vdir, 16'(vlen), vbase);
      check_eq("R2 load", {15'd0, xfer_en, bytes_left}, {15'd0, 1'b1, 16'(vlen)});
      if (vdir) begin
        wait_cnt0();
        tick();
        check_eq("R8 data_end rx", {30'd0, data_end, block_end}, 32'h3);
        if (vlen == 64) begin
          check_eq("R10 rx full flags", 32'(rx_flags), 32'b11101);
          check_eq("R11 tx side silent", 32'(tx_flags), 0);
        end
        for (int k = 0; k < nw; k++) begin
          pop_word(d, e);
          check_eq("R4 rx word", d, exp_word(vbase, k, vlen));
        end
        tick(); tick();
        check_eq("R9 rx en clears", 32'(xfer_en), 0);
      end else begin
        for (int k = 0; k < nw; k++) push_word(exp_word(vbase, k, 4 * nw));
        wait_idle();
        check_eq("R5 tx count", rec_n, vlen);
        bad = 0;
        for (int i = 0; i < vlen; i++) if (rec[i] !== vbase + 8'(i)) bad++;
        check_eq("R5 tx byte order", bad, 0);
        check_eq("R8 data_end tx", 32'(data_end), 1);
      end
    end

    // R6 host push ignored while idle; pop then finds empty ring (R7)
    push_word(32'hDEADBEEF);
    pop_word(d, e);
    check_eq("R6 idle push dropped", {31'd0, e}, 1);
    check_eq("R7 empty pop data", d, 0);

    // R10/R11 tx flags at zero occupancy, R7 pop rejected while sending
    do_start(1'b0, 16'd4, 8'h90);
    check_eq("R10 tx empty flags", 32'(tx_flags), 32'b10011);
    check_eq("R11 rx side silent", 32'(rx_flags), 0);
    pop_word(d, e);
    check_eq("R7 tx pop rejected", {31'd0, e}, 1);
    push_word(32'h93929190);
    wait_idle();
    check_eq("R5 tx after reject", {rec_n[7:0], rec[0], rec[3], 8'd0}, {8'd4, 8'h90, 8'h93, 8'd0});

    // R3 stall when card not ready
    card_rdy = 1'b0;
    do_start(1'b1, 16'd4, 8'h55);
    repeat (5) tick();
    check_eq("R3 stall not ready", 32'(bytes_left), 4);
    check_eq("R3 no take", 32'(card_rd_take), 0);
    card_rdy = 1'b1;
    wait_cnt0();
    tick();
    pop_word(d, e);
    check_eq("R4 after stall", d, 32'h58575655);
    tick(); tick();

    // R3/R10 stall on full ring, resume after one pop
    do_start(1'b1, 16'd68, 8'h01);
    repeat (80) tick();
    check_eq("R3 full stall", 32'(bytes_left), 4);
    check_eq("R10 full flags", 32'(rx_flags), 32'b11101);
    pop_word(d, e);
    check_eq("R6 fifo order", d, exp_word(8'h01, 0, 68));
    check_eq("R10 flags follow pop", 32'(rx_flags), 32'b10101);
    wait_cnt0();
    tick();
    for (int k = 1; k < 17; k++) begin
      pop_word(d, e);
      if (k == 16) check_eq("R4 last word after resume", d, exp_word(8'h01, 16, 68));
    end
    tick(); tick();
    check_eq("R9 idle after drain", 32'(xfer_en), 0);

    // R2/R8/R9 zero length
    do_start(1'b1, 16'd0, 8'h00);
    check_eq("R2 end cleared on start", {30'd0, xfer_en, data_end}, 32'h2);
    tick();
    check_eq("R8 R9 zero length", {30'd0, xfer_en, data_end}, 32'h1);

    report();
    $finish;
  end

endmodule